// File: doc/BRIEF.md
# Configuration Request Packet Formatter

This block turns one configuration-space access into a request packet for a root port transmit path. A request carries a target bus, a device/function number, a byte offset, an access size of one, two or four bytes, a direction and write data. The block builds a three-dword request header. For writes and reads it also builds a data dword. It sends the packet as 64-bit beats on a valid/ready stream that has start and end flags. It works out the byte enables from size and offset. It masks the write data to the access size and moves it into its byte lane. It picks the type 0 or type 1 encoding against a stored root bus number, and it updates that number when software rewrites the primary-bus register of the root port.

Both edges of the block are valid/ready. On the request side a transfer happens on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the final beat of the packet has been taken downstream, so only one request is in flight at a time. On the beat side, a beat whose `pkt_valid` is high while `pkt_ready` is low stays on the outputs unchanged until it is taken. Nothing inside the block is lost or reordered by back-pressure.

Top module: `cfg_req_packer`

## Requirements
- R1: After reset, `pkt_valid` and `busy` are 0, `req_ready` is 1 and `root_bus` is 0.
- R2: Header dword 0 is the format/type code in bits 31:24 and the value 1 in bits 9:0, with all other bits 0. The codes are 0x04 for a type 0 read, 0x44 for a type 0 write, 0x05 for a type 1 read and 0x45 for a type 1 write.
- R3: The type 0 code is used when `req_bus` equals `root_bus` at acceptance. Otherwise the type 1 code is used.
- R4: Header dword 1 is {`root_bus`, 8'h00} in bits 31:16, the tag in bits 15:8 (0x1D for reads, 0x10 for writes) and the byte enables in bits 7:0.
- R5: `req_size` encodes the access size as 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. The byte enables are 0x01 << offset[1:0], 0x03 << offset[1:0] and 0x0F for those sizes.
- R6: Header dword 2 is `req_bus` in bits 31:24 and `req_devfn` in bits 23:16. Its low 16 bits hold the offset with bits 1:0 cleared.
- R7: The data dword of a write is `req_wdata` masked to the access size and then shifted left by 8 × offset[1:0]. For a read the data dword is 0.
- R8: The first beat is {dword 1, dword 0}, with the start flag set and the end flag clear.
- R9: A write whose offset has bits 2:0 all zero takes three beats. The second beat is {32'h0, dword 2} with no flags. The third beat is {32'h0, data} with the end flag set.
- R10: Every other write, and every read, takes two beats. The second beat is {data, dword 2} with the end flag set.
- R11: When the final beat of a write to bus `root_bus` at offset 0x18 is accepted, `root_bus` takes the low byte of the data dword on the next cycle. No other request changes `root_bus`.
- R12: `busy` is 1, and `req_ready` is 0, from the cycle after acceptance until the final beat is accepted. A stalled beat holds its data and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_offset | input | 12 | Byte offset in configuration space |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write value, right-aligned |
| pkt_valid | output | 1 | Beat offered |
| pkt_ready | input | 1 | Downstream takes the beat |
| pkt_data | output | 64 | Beat payload |
| pkt_sop | output | 1 | First beat of packet |
| pkt_eop | output | 1 | Last beat of packet |
| busy | output | 1 | Packet in progress |
| root_bus | output | 8 | Stored root bus number |

## Verification
The hardest case to reach is a change of the root bus number in the middle of a stream. The stored value has to change only on the handshake of the final beat of an aligned three-beat write, and the very next request must then take its type and requester ID from the new value. The bench reaches this case by writing the primary-bus register at offset 0x18 while random back-pressure stretches the packet. It then sends a request to the new root bus at once, and another to the old one. Near-miss writes are also sent: offset 0x19, and offset 0x18 on a bus other than the root. They show that `root_bus` is left unchanged.

// File: rtl/cfg_pkt_pkg.sv
`timescale 1ns/1ps
package cfg_pkt_pkg;
  localparam int DW_W   = 32;
  localparam int BEAT_W = 64;

  localparam logic [7:0] FT_RD_T0 = 8'h04;
  localparam logic [7:0] FT_WR_T0 = 8'h44;
  localparam logic [7:0] FT_RD_T1 = 8'h05;
  localparam logic [7:0] FT_WR_T1 = 8'h45;
  localparam logic [7:0] TAG_RD   = 8'h1D;
  localparam logic [7:0] TAG_WR   = 8'h10;
  localparam logic [9:0] LEN_ONE  = 10'd1;
  localparam int PRI_BUS_OFS      = 'h18;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_MID  = 2'd2,
    ST_LAST = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic [DW_W-1:0] hdr0;
    logic [DW_W-1:0] hdr1;
    logic [DW_W-1:0] hdr2;
    logic [DW_W-1:0] data;
    logic            three_beat;
    logic            root_upd;
  } pkt_ctx_t;
endpackage

// File: rtl/cfg_hdr_build.sv
`timescale 1ns/1ps
module cfg_hdr_build
  import cfg_pkt_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEVFN_W = 8,
  parameter int OFS_W = 12
) (
  input  logic               is_write,
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [OFS_W-1:0]   offset,
  input  logic [1:0]         size,
  input  logic [DW_W-1:0]    wdata,
  input  logic [BUS_W-1:0]   root_bus,
  output pkt_ctx_t           ctx
);
  localparam int LANES   = DW_W / 8;
  localparam int OFS_PAD = 16 - OFS_W;

  logic [1:0]       lane;
  logic             type0;
  logic [7:0]       fmt_code;
  logic [7:0]       tag;
  logic [7:0]       be;
  logic [DW_W-1:0]  masked;
  logic [DW_W-1:0]  shifted;
  logic [LANES-1:0] keep;

  assign lane  = offset[1:0];
  assign type0 = (bus == root_bus);

  always_comb begin
    unique case ({is_write, type0})
      2'b01:   fmt_code = FT_RD_T0;
      2'b00:   fmt_code = FT_RD_T1;
      2'b11:   fmt_code = FT_WR_T0;
      default: fmt_code = FT_WR_T1;
    endcase
    tag = is_write ? TAG_WR : TAG_RD;
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: begin be = 8'(8'h01 << lane); keep = LANES'(1); end
      SZ_HALF: begin be = 8'(8'h03 << lane); keep = LANES'(3); end
      default: begin be = 8'h0F;             keep = '1;       end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign masked[g*8 +: 8] = keep[g] ? wdata[g*8 +: 8] : 8'h00;
  end

  assign shifted = is_write ? (masked << {lane, 3'b000}) : '0;

  always_comb begin
    ctx.hdr0       = {fmt_code, 14'h0, LEN_ONE};
    ctx.hdr1       = {root_bus, 8'h00, tag, be};
    ctx.hdr2       = {bus, devfn, {OFS_PAD{1'b0}}, offset[OFS_W-1:2], 2'b00};
    ctx.data       = shifted;
    ctx.three_beat = is_write && (offset[2:0] == 3'b000);
    ctx.root_upd   = is_write && type0 && (offset == OFS_W'(PRI_BUS_OFS));
  end
endmodule

// File: rtl/cfg_beat_seq.sv
`timescale 1ns/1ps
module cfg_beat_seq
  import cfg_pkt_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  pkt_ctx_t          ctx_in,
  input  logic              pkt_ready,
  output logic              pkt_valid,
  output logic [BEAT_W-1:0] pkt_data,
  output logic              pkt_sop,
  output logic              pkt_eop,
  output logic              busy,
  output logic              root_we,
  output logic [BUS_W-1:0]  root_wval
);
  seq_st_e  state, state_nx;
  pkt_ctx_t ctx_q;
  logic     fire;

  assign fire = pkt_valid && pkt_ready;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (accept) state_nx = ST_HDR;
      ST_HDR:  if (fire) state_nx = ctx_q.three_beat ? ST_MID : ST_LAST;
      ST_MID:  if (fire) state_nx = ST_LAST;
      default: if (fire) state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ctx_q <= '0;
    end else begin
      state <= state_nx;
      if (accept && state == ST_IDLE) ctx_q <= ctx_in;
    end
  end

  always_comb begin
    pkt_valid = (state != ST_IDLE);
    pkt_sop   = (state == ST_HDR);
    pkt_eop   = (state == ST_LAST);
    unique case (state)
      ST_HDR:  pkt_data = {ctx_q.hdr1, ctx_q.hdr0};
      ST_MID:  pkt_data = {32'h0, ctx_q.hdr2};
      ST_LAST: pkt_data = ctx_q.three_beat ? {32'h0, ctx_q.data}
                                           : {ctx_q.data, ctx_q.hdr2};
      default: pkt_data = '0;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign root_we   = fire && (state == ST_LAST) && ctx_q.root_upd;
  assign root_wval = ctx_q.data[BUS_W-1:0];
endmodule

// File: rtl/cfg_root_bus_reg.sv
`timescale 1ns/1ps
module cfg_root_bus_reg #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [BUS_W-1:0] wval,
  output logic [BUS_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)  value <= '0;
    else if (we) value <= wval;
  end
endmodule

// File: rtl/cfg_req_packer.sv
`timescale 1ns/1ps
module cfg_req_packer
  import cfg_pkt_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEVFN_W = 8,
  parameter int OFS_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [OFS_W-1:0]   req_offset,
  input  logic [1:0]         req_size,
  input  logic [31:0]        req_wdata,
  output logic               pkt_valid,
  input  logic               pkt_ready,
  output logic [63:0]        pkt_data,
  output logic               pkt_sop,
  output logic               pkt_eop,
  output logic               busy,
  output logic [BUS_W-1:0]   root_bus
);
  pkt_ctx_t         ctx;
  logic             accept;
  logic             root_we;
  logic [BUS_W-1:0] root_wval;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  cfg_hdr_build #(.BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFS_W(OFS_W)) u_hdr (
    .is_write(req_write), .bus(req_bus), .devfn(req_devfn),
    .offset(req_offset), .size(req_size), .wdata(req_wdata),
    .root_bus(root_bus), .ctx(ctx)
  );

  cfg_beat_seq #(.BUS_W(BUS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ctx_in(ctx),
    .pkt_ready(pkt_ready), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .busy(busy),
    .root_we(root_we), .root_wval(root_wval)
  );

  cfg_root_bus_reg #(.BUS_W(BUS_W)) u_root (
    .clk(clk), .rst_n(rst_n), .we(root_we), .wval(root_wval),
    .value(root_bus)
  );
endmodule

// File: rtl/cfg_req_packer_chk.sv
`timescale 1ns/1ps
module cfg_req_packer_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic [63:0]      pkt_data,
  input logic             pkt_sop,
  input logic             pkt_eop,
  input logic             busy,
  input logic [BUS_W-1:0] root_bus
);
  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data) && $stable(pkt_sop) && $stable(pkt_eop));

  // R12
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !(pkt_sop && pkt_eop));

  // R8
  accept_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> pkt_valid && pkt_sop);

  // R11
  root_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_valid && pkt_ready && pkt_eop) |=> $stable(root_bus));

  // R12
  idle_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && pkt_eop |=> !busy);
endmodule

bind cfg_req_packer cfg_req_packer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
  .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .busy(busy), .root_bus(root_bus)
);

// File: tb/cfg_req_packer_test.sv
`timescale 1ns/1ps
module cfg_req_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [7:0]  req_devfn = '0;
  logic [11:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        pkt_valid;
  logic        pkt_ready = 1'b1;
  logic [63:0] pkt_data;
  logic        pkt_sop, pkt_eop, busy;
  logic [7:0]  root_bus;

  int n_chk = 0;
  int n_bad = 0;
  int bp_mode = 0;
  logic [7:0] root_m = 8'h00;

  typedef struct packed { logic [63:0] d; logic sop; logic eop; } beat_t;
  beat_t exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  cfg_req_packer uut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #2;
    case (bp_mode)
      0: pkt_ready = 1'b1;
      1: pkt_ready = ($urandom % 3) != 0;
      default: pkt_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && pkt_valid && pkt_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected beat", pkt_data, 64'h0);
      end else begin
        beat_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(pkt_data == e.d && pkt_sop == e.sop && pkt_eop == e.eop, t, "beat",
            {pkt_data[61:0], pkt_sop, pkt_eop}, {e.d[61:0], e.sop, e.eop});
      end
    end
  end

  task automatic send(input bit w, input logic [7:0] bus, input logic [7:0] dfn,
                      input logic [11:0] ofs, input logic [1:0] sz, input logic [31:0] wd);
    logic [7:0] be, ft, tg;
    logic [31:0] msk, dat, h0, h1, h2;
    bit t0;
    t0 = (bus == root_m);
    ft = w ? (t0 ? 8'h44 : 8'h45) : (t0 ? 8'h04 : 8'h05);
    tg = w ? 8'h10 : 8'h1D;
    case (sz)
      2'd0: begin be = 8'h01 << ofs[1:0]; msk = wd & 32'hFF; end
      2'd1: begin be = 8'h03 << ofs[1:0]; msk = wd & 32'hFFFF; end
      default: begin be = 8'h0F; msk = wd; end
    endcase
    dat = w ? (msk << (8 * ofs[1:0])) : 32'h0;
    h0 = {ft, 24'h000001};
    h1 = {root_m, 8'h00, tg, be};
    h2 = {bus, dfn, 4'h0, ofs[11:2], 2'b00};
    exp_q.push_back('{{h1, h0}, 1'b1, 1'b0}); tag_q.push_back("R8");
    if (w && ofs[2:0] == 3'b000) begin
      exp_q.push_back('{{32'h0, h2}, 1'b0, 1'b0}); tag_q.push_back("R9");
      exp_q.push_back('{{32'h0, dat}, 1'b0, 1'b1}); tag_q.push_back("R9");
    end else begin
      exp_q.push_back('{{dat, h2}, 1'b0, 1'b1}); tag_q.push_back("R10");
    end
    if (w && t0 && ofs == 12'h018) root_m = dat[7:0];
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bus = bus; req_devfn = dfn;
    req_offset = ofs; req_size = sz; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R12", "watchdog", 64'h0, 64'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pkt_valid == 0 && busy == 0, "R1", "reset idle", {pkt_valid, busy}, 0);
    chk(req_ready == 1, "R1", "reset ready", req_ready, 1);
    chk(root_bus == 0, "R1", "reset root", root_bus, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R6: type 0 read and type 1 reads, R5 byte enables
    send(0, 8'h00, 8'h00, 12'h000, 2'd2, 0);
    send(0, 8'h01, 8'h08, 12'h013, 2'd0, 0);
    send(0, 8'h02, 8'h10, 12'h102, 2'd1, 0);
    // R7 R9 R10 writes
    send(1, 8'h00, 8'h00, 12'h008, 2'd2, 32'hCAFE_F00D);
    send(1, 8'h03, 8'h01, 12'h00D, 2'd0, 32'h1234_56AB);
    send(1, 8'h03, 8'h01, 12'h006, 2'd1, 32'h1234_5678);
    send(1, 8'h04, 8'h02, 12'hFFC, 2'd3, 32'h8765_4321);
    drain();

    // R12 stall: beat held while ready low
    bp_mode = 2;
    @(negedge clk);
    send(0, 8'h07, 8'h00, 12'h040, 2'd2, 0);
    begin
      logic [63:0] first;
      first = pkt_data;
      chk(busy == 1 && req_ready == 0, "R12", "busy after accept", {busy, req_ready}, 2'b10);
      repeat (4) @(negedge clk);
      chk(pkt_valid && pkt_sop && pkt_data == first, "R12", "stall hold", pkt_data, first);
    end
    bp_mode = 0;
    drain();
    chk(busy == 0 && req_ready == 1, "R12", "idle after last", {busy, req_ready}, 2'b01);

    // R11 root bus tracking under back-pressure
    bp_mode = 1;
    send(1, 8'h00, 8'h00, 12'h018, 2'd0, 32'hFFFF_FF05);
    send(0, 8'h05, 8'h00, 12'h000, 2'd2, 0);
    send(0, 8'h00, 8'h00, 12'h000, 2'd2, 0);
    drain();
    chk(root_bus == 8'h05, "R11", "root updated", root_bus, 8'h05);
    send(1, 8'h02, 8'h00, 12'h018, 2'd2, 32'h0000_0009);
    drain();
    chk(root_bus == 8'h05, "R11", "other bus ignored", root_bus, 8'h05);
    send(1, 8'h05, 8'h00, 12'h019, 2'd0, 32'h0000_0033);
    drain();
    chk(root_bus == 8'h05, "R11", "offset 0x19 ignored", root_bus, 8'h05);
    send(0, 8'h05, 8'h00, 12'h018, 2'd2, 0);
    drain();
    chk(root_bus == 8'h05, "R11", "read ignored", root_bus, 8'h05);
    send(1, 8'h05, 8'h00, 12'h018, 2'd2, 32'h00AA_BB0C);
    send(0, 8'h0C, 8'h00, 12'h004, 2'd1, 0);
    drain();
    chk(root_bus == 8'h0C, "R11", "root updated again", root_bus, 8'h0C);

    // R3 R5 R7 random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] b;
      b = ($urandom % 2) ? root_m : 8'($urandom);
      send(1'($urandom), b, 8'($urandom), 12'($urandom), 2'($urandom), $urandom);
    end
    drain();
    chk(root_bus == root_m, "R11", "root after mix", root_bus, root_m);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule